// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block sits between instruction fetch and two execution units, a memory unit and an integer unit. It takes one 64-bit instruction word at a time together with the address of that word. Two format bits inside the word say how the two 32-bit halves are to be issued. The word may be one long instruction, or two short instructions issued together, one to each unit. It may also be two short instructions issued one after the other, in either order. The left slot is the upper half of the word and the right slot is the lower half.

Each issue cycle raises one or more unit strobes, and each strobe carries its slot. The execution units report back in the same cycle: whether a branch was taken, its target, and a request to cancel the next slot. The sequencer merges these reports into a single next address. It publishes that address one cycle after the last issue cycle of the word, with a one-cycle completion pulse and an error flag. The error flag is set when both slots of a parallel pair branch. A new word is accepted through a ready/valid handshake, and only while the sequencer is idle.

Report channels: the primary channel (`pri_*`) reports the only slot issued in a cycle. In a parallel pair it reports the memory-unit slot instead. The secondary channel (`sec_*`) reports the integer-unit slot of a parallel pair and is ignored at all other times.

Top module: `dual_issue_seq`

## Requirements
- R1: The issue form is {word[63], word[31]}. Value 3 is long, 0 is parallel, 1 is left-then-right and 2 is right-then-left. The left slot is word[63:32] and the right slot is word[31:0].
- R2: A long word issues in exactly one cycle. `long_go` is high with the full word on `long_word`, and no other strobe is raised in that cycle.
- R3: A parallel word issues in one cycle. `mem_go` carries the left slot and `int_go` carries the right slot, both in the same cycle.
- R4: In a parallel pair, a branch reported by only one slot gives that slot's target. A branch reported by both slots gives `err`=1 and the sequential address, with no branch taken. A kill request in a parallel pair has no effect.
- R5: A left-then-right word issues the left slot on `mem_go` in the first cycle. In the next cycle it issues the right slot on `any_go`.
- R6: A right-then-left word issues the right slot on `int_go` in the first cycle. In the next cycle it issues the left slot on `any_go`.
- R7: In a sequential pair, if the first slot branches or requests a kill, the second slot is not issued. The next address is then the branch target, or the sequential address when only a kill was requested.
- R8: When no slot branches, the next address is the word's address plus 8, modulo 2^32. For a single slot, a long word or a second sequential slot, a reported branch gives its target.
- R9: `in_ready` is high only while no word is being issued. A word is taken only when `in_valid` and `in_ready` are both high, and `in_valid` is ignored while `in_ready` is low.
- R10: `done` pulses for one cycle, one cycle after the last issue cycle of a word. `next_pc` and `err` are valid in that cycle.
- R11: After reset, `in_ready` is high, and all strobes, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Sequencer idle, word can be taken |
| in_word | input | 64 | Instruction word |
| in_pc | input | 32 | Address of the instruction word |
| long_go | output | 1 | Long instruction issue strobe |
| long_word | output | 64 | Long instruction, zero when not strobed |
| mem_go | output | 1 | Memory-unit slot issue strobe |
| mem_insn | output | 32 | Memory-unit slot, zero when not strobed |
| int_go | output | 1 | Integer-unit slot issue strobe |
| int_insn | output | 32 | Integer-unit slot, zero when not strobed |
| any_go | output | 1 | Second sequential slot strobe, either unit |
| any_insn | output | 32 | Second sequential slot, zero when not strobed |
| pri_br | input | 1 | Primary slot took a branch |
| pri_tgt | input | 32 | Primary slot branch target |
| pri_kill | input | 1 | Primary slot cancels the following slot |
| sec_br | input | 1 | Parallel integer slot took a branch |
| sec_tgt | input | 32 | Parallel integer slot branch target |
| done | output | 1 | Word complete, next_pc valid |
| next_pc | output | 32 | Merged next address |
| err | output | 1 | Both parallel slots branched |

## Verification
Several rules hold on every cycle and are checked that way. A long strobe is always alone. A second-slot strobe always follows a single bound-unit strobe. `done` always follows an issue cycle. `err` appears only after a cycle with both units strobed. `in_ready` drops right after a word is taken. The bench covers what needs a scenario. It sweeps all four forms against every mix of branch and kill reports from both slots, at several addresses including one that wraps. It checks slot routing, cancellation of the second slot, target selection and the handling of a double branch. While each word is in progress it holds `in_valid` high with a decoy word, to show that a busy sequencer takes nothing.

// File: rtl/dis_pkg.sv
package dis_pkg;

  typedef enum logic [1:0] {
    FMT_PAR  = 2'd0,
    FMT_LR   = 2'd1,
    FMT_RL   = 2'd2,
    FMT_LONG = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ONE    = 2'd1,
    ST_FIRST  = 2'd2,
    ST_SECOND = 2'd3
  } st_e;

  // Issue form from the upper-half and lower-half format bits
  function automatic fmt_e fmt_of(input logic hi_bit, input logic lo_bit);
    return fmt_e'({hi_bit, lo_bit});
  endfunction

endpackage

// File: rtl/slot_split.sv
module slot_split
  import dis_pkg::*;
#(
  parameter int SLOTW = 32
) (
  input  logic [2*SLOTW-1:0] word,
  output fmt_e               kind,
  output logic [SLOTW-1:0]   left_slot,
  output logic [SLOTW-1:0]   right_slot
);

  localparam int WORDW = 2 * SLOTW;

  always_comb begin
    left_slot  = word[WORDW-1:SLOTW];
    right_slot = word[SLOTW-1:0];
    kind       = fmt_of(word[WORDW-1], word[SLOTW-1]);
  end

endmodule

// File: rtl/issue_fsm.sv
module issue_fsm
  import dis_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  fmt_e in_kind,
  input  logic first_stop,
  output st_e  state,
  output logic in_ready,
  output logic accept
);

  st_e state_d;
  st_e state_q;

  always_comb begin
    in_ready = (state_q == ST_IDLE);
    accept   = in_ready && in_valid;
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (in_kind == FMT_LONG || in_kind == FMT_PAR) state_d = ST_ONE;
          else                                           state_d = ST_FIRST;
        end
      end
      ST_ONE:    state_d = ST_IDLE;
      ST_FIRST:  state_d = first_stop ? ST_IDLE : ST_SECOND;
      ST_SECOND: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/issue_drive.sv
module issue_drive
  import dis_pkg::*;
#(
  parameter int SLOTW = 32
) (
  input  st_e                state,
  input  fmt_e               kind,
  input  logic [SLOTW-1:0]   left_slot,
  input  logic [SLOTW-1:0]   right_slot,
  output logic               long_go,
  output logic [2*SLOTW-1:0] long_word,
  output logic               mem_go,
  output logic [SLOTW-1:0]   mem_insn,
  output logic               int_go,
  output logic [SLOTW-1:0]   int_insn,
  output logic               any_go,
  output logic [SLOTW-1:0]   any_insn
);

  always_comb begin
    long_go   = 1'b0;
    long_word = '0;
    mem_go    = 1'b0;
    mem_insn  = '0;
    int_go    = 1'b0;
    int_insn  = '0;
    any_go    = 1'b0;
    any_insn  = '0;
    unique case (state)
      ST_ONE: begin
        if (kind == FMT_LONG) begin
          long_go   = 1'b1;
          long_word = {left_slot, right_slot};
        end else begin
          mem_go   = 1'b1;
          mem_insn = left_slot;
          int_go   = 1'b1;
          int_insn = right_slot;
        end
      end
      ST_FIRST: begin
        if (kind == FMT_LR) begin
          mem_go   = 1'b1;
          mem_insn = left_slot;
        end else begin
          int_go   = 1'b1;
          int_insn = right_slot;
        end
      end
      ST_SECOND: begin
        any_go   = 1'b1;
        any_insn = (kind == FMT_LR) ? right_slot : left_slot;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pc_merge.sv
module pc_merge
  import dis_pkg::*;
#(
  parameter int PCW   = 32,
  parameter int SLOTW = 32
) (
  input  st_e            state,
  input  fmt_e           kind,
  input  logic [PCW-1:0] cur_pc,
  input  logic           pri_br,
  input  logic [PCW-1:0] pri_tgt,
  input  logic           pri_kill,
  input  logic           sec_br,
  input  logic [PCW-1:0] sec_tgt,
  output logic           fin,
  output logic [PCW-1:0] nxt_pc,
  output logic           dbl_br
);

  localparam int PC_STEP = (2 * SLOTW) / 8;

  logic [PCW-1:0] seq_pc;

  always_comb begin
    seq_pc = cur_pc + PCW'(PC_STEP);
    fin    = 1'b0;
    nxt_pc = seq_pc;
    dbl_br = 1'b0;
    unique case (state)
      ST_ONE: begin
        fin = 1'b1;
        if (kind == FMT_PAR) begin
          if (pri_br && sec_br) dbl_br = 1'b1;
          else if (pri_br)      nxt_pc = pri_tgt;
          else if (sec_br)      nxt_pc = sec_tgt;
        end else if (pri_br) begin
          nxt_pc = pri_tgt;
        end
      end
      ST_FIRST: begin
        fin = pri_br || pri_kill;
        if (pri_br) nxt_pc = pri_tgt;
      end
      ST_SECOND: begin
        fin = 1'b1;
        if (pri_br) nxt_pc = pri_tgt;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dual_issue_seq.sv
module dual_issue_seq
  import dis_pkg::*;
#(
  parameter int PCW   = 32,
  parameter int SLOTW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2*SLOTW-1:0] in_word,
  input  logic [PCW-1:0]     in_pc,
  output logic               long_go,
  output logic [2*SLOTW-1:0] long_word,
  output logic               mem_go,
  output logic [SLOTW-1:0]   mem_insn,
  output logic               int_go,
  output logic [SLOTW-1:0]   int_insn,
  output logic               any_go,
  output logic [SLOTW-1:0]   any_insn,
  input  logic               pri_br,
  input  logic [PCW-1:0]     pri_tgt,
  input  logic               pri_kill,
  input  logic               sec_br,
  input  logic [PCW-1:0]     sec_tgt,
  output logic               done,
  output logic [PCW-1:0]     next_pc,
  output logic               err
);

  localparam int WORDW = 2 * SLOTW;

  st_e              state;
  logic             accept;
  logic             fin;
  logic             dbl_br;
  logic [PCW-1:0]   nxt_pc;
  fmt_e             in_kind;
  fmt_e             hold_kind;
  logic [SLOTW-1:0] left_slot;
  logic [SLOTW-1:0] right_slot;

  logic [WORDW-1:0] word_q, word_d;
  logic [PCW-1:0]   pc_q, pc_d;
  logic             done_q, done_d;
  logic [PCW-1:0]   npc_q, npc_d;
  logic             err_q, err_d;

  assign in_kind = fmt_of(in_word[WORDW-1], in_word[SLOTW-1]);

  issue_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_kind    (in_kind),
    .first_stop (fin),
    .state      (state),
    .in_ready   (in_ready),
    .accept     (accept)
  );

  slot_split #(.SLOTW(SLOTW)) u_split (
    .word       (word_q),
    .kind       (hold_kind),
    .left_slot  (left_slot),
    .right_slot (right_slot)
  );

  issue_drive #(.SLOTW(SLOTW)) u_drive (
    .state      (state),
    .kind       (hold_kind),
    .left_slot  (left_slot),
    .right_slot (right_slot),
    .long_go    (long_go),
    .long_word  (long_word),
    .mem_go     (mem_go),
    .mem_insn   (mem_insn),
    .int_go     (int_go),
    .int_insn   (int_insn),
    .any_go     (any_go),
    .any_insn   (any_insn)
  );

  pc_merge #(.PCW(PCW), .SLOTW(SLOTW)) u_merge (
    .state    (state),
    .kind     (hold_kind),
    .cur_pc   (pc_q),
    .pri_br   (pri_br),
    .pri_tgt  (pri_tgt),
    .pri_kill (pri_kill),
    .sec_br   (sec_br),
    .sec_tgt  (sec_tgt),
    .fin      (fin),
    .nxt_pc   (nxt_pc),
    .dbl_br   (dbl_br)
  );

  // Capture and result next-state logic with explicit enables
  always_comb begin
    word_d = word_q;
    pc_d   = pc_q;
    if (accept) begin
      word_d = in_word;
      pc_d   = in_pc;
    end
    done_d = fin;
    npc_d  = npc_q;
    err_d  = 1'b0;
    if (fin) begin
      npc_d = nxt_pc;
      err_d = dbl_br;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pc_q   <= '0;
      done_q <= 1'b0;
      npc_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      pc_q   <= pc_d;
      done_q <= done_d;
      npc_q  <= npc_d;
      err_q  <= err_d;
    end
  end

  assign done    = done_q;
  assign next_pc = npc_q;
  assign err     = err_q;

endmodule

// File: rtl/dual_issue_seq_chk.sv
module dual_issue_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic long_go,
  input logic mem_go,
  input logic int_go,
  input logic any_go,
  input logic done,
  input logic err
);

  logic any_strobe;
  assign any_strobe = long_go || mem_go || int_go || any_go;

  AST_LONG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    long_go |-> !(mem_go || int_go || any_go)); // R2

  AST_SECOND_FOLLOWS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |-> ($past(mem_go) != $past(int_go)) && !$past(long_go) && !$past(any_go)); // R5

  AST_SECOND_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |-> !(mem_go || int_go || long_go)); // R6

  AST_ERR_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && $past(mem_go && int_go)); // R4

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(any_strobe)); // R10

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready && any_strobe); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !any_strobe); // R9

endmodule

bind dual_issue_seq dual_issue_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .long_go  (long_go),
  .mem_go   (mem_go),
  .int_go   (int_go),
  .any_go   (any_go),
  .done     (done),
  .err      (err)
);

// File: tb/dual_issue_seq_test.sv
`timescale 1ns/1ps
module dual_issue_seq_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_word;
  logic [31:0] in_pc;
  logic        long_go;
  logic [63:0] long_word;
  logic        mem_go;
  logic [31:0] mem_insn;
  logic        int_go;
  logic [31:0] int_insn;
  logic        any_go;
  logic [31:0] any_insn;
  logic        pri_br;
  logic [31:0] pri_tgt;
  logic        pri_kill;
  logic        sec_br;
  logic [31:0] sec_tgt;
  logic        done;
  logic [31:0] next_pc;
  logic        err;

  int checks;
  int fails;
  int cycles;
  bit finished;

  dual_issue_seq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_pc(in_pc),
    .long_go(long_go), .long_word(long_word),
    .mem_go(mem_go), .mem_insn(mem_insn),
    .int_go(int_go), .int_insn(int_insn),
    .any_go(any_go), .any_insn(any_insn),
    .pri_br(pri_br), .pri_tgt(pri_tgt), .pri_kill(pri_kill),
    .sec_br(sec_br), .sec_tgt(sec_tgt),
    .done(done), .next_pc(next_pc), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_res();
    pri_br = 0; pri_tgt = 0; pri_kill = 0; sec_br = 0; sec_tgt = 0;
  endtask

  // One word: form t, branch/kill mix m, address pc
  task automatic run(input int t, input int m, input logic [31:0] pc);
    logic [31:0] lft, rgt, lt, rt, exp_pc;
    logic lbr, lkl, rbr, rkl, exp_err;
    lbr = m[0]; lkl = m[1]; rbr = m[2]; rkl = m[3];
    lft = {t[1], 31'(32'h1357_0000 + t * 97 + m * 13)};
    rgt = {t[0], 31'(32'h2468_0000 + t * 59 + m * 7)};
    lt  = pc ^ 32'h0000_4440;
    rt  = pc ^ 32'h0001_8880;
    exp_err = 0;

    @(negedge clk);
    chk("R9 ready when idle", {63'd0, in_ready}, 64'd1);
    in_valid = 1; in_word = {lft, rgt}; in_pc = pc;
    @(negedge clk);
    // decoy held high while busy: must not be taken (R9)
    in_word = 64'hDEAD_BEEF_0BAD_F00D; in_pc = 32'h5555_0000;
    chk("R9 busy not ready", {63'd0, in_ready}, 64'd0);
    chk("R10 no done mid-word", {63'd0, done}, 64'd0);
    clear_res();
    case (t)
      3: begin
        chk("R2 long strobes", {60'd0, long_go, mem_go, int_go, any_go}, 64'b1000);
        chk("R1 R2 long word", long_word, {lft, rgt});
        pri_br = lbr; pri_tgt = lt; pri_kill = lkl;
        exp_pc = lbr ? lt : pc + 32'd8;
      end
      0: begin
        chk("R3 parallel strobes", {60'd0, long_go, mem_go, int_go, any_go}, 64'b0110);
        chk("R1 R3 mem gets left", {32'd0, mem_insn}, {32'd0, lft});
        chk("R1 R3 int gets right", {32'd0, int_insn}, {32'd0, rgt});
        pri_br = lbr; pri_tgt = lt; pri_kill = lkl;
        sec_br = rbr; sec_tgt = rt;
        if (lbr && rbr) begin exp_err = 1; exp_pc = pc + 32'd8; end
        else if (lbr) exp_pc = lt;
        else if (rbr) exp_pc = rt;
        else exp_pc = pc + 32'd8;
      end
      default: begin
        if (t == 1) begin
          chk("R5 first on mem", {60'd0, long_go, mem_go, int_go, any_go}, 64'b0100);
          chk("R5 first slot left", {32'd0, mem_insn}, {32'd0, lft});
          pri_br = lbr; pri_tgt = lt; pri_kill = lkl;
        end else begin
          chk("R6 first on int", {60'd0, long_go, mem_go, int_go, any_go}, 64'b0010);
          chk("R6 first slot right", {32'd0, int_insn}, {32'd0, rgt});
          pri_br = rbr; pri_tgt = rt; pri_kill = rkl;
        end
        if (pri_br || pri_kill) begin
          exp_pc = pri_br ? pri_tgt : pc + 32'd8;
        end else begin
          @(negedge clk);
          clear_res();
          chk("R9 busy in second", {63'd0, in_ready}, 64'd0);
          chk("R5 R6 second on any", {60'd0, long_go, mem_go, int_go, any_go}, 64'b0001);
          if (t == 1) begin
            chk("R5 second slot right", {32'd0, any_insn}, {32'd0, rgt});
            pri_br = rbr; pri_tgt = rt; pri_kill = rkl;
          end else begin
            chk("R6 second slot left", {32'd0, any_insn}, {32'd0, lft});
            pri_br = lbr; pri_tgt = lt; pri_kill = lkl;
          end
          exp_pc = pri_br ? pri_tgt : pc + 32'd8;
        end
      end
    endcase
    @(negedge clk);
    in_valid = 0;
    clear_res();
    chk("R7 R10 done pulse, no further strobe",
        {59'd0, done, long_go, mem_go, int_go, any_go}, 64'b10000);
    chk("R4 R7 R8 next address", {32'd0, next_pc}, {32'd0, exp_pc});
    chk("R4 error flag", {63'd0, err}, {63'd0, exp_err});
    @(negedge clk);
    chk("R10 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    checks = 0; fails = 0; cycles = 0; finished = 0;
    rst_n = 0; in_valid = 0; in_word = 0; in_pc = 0;
    clear_res();
    #9;
    chk("R11 reset ready", {63'd0, in_ready}, 64'd1);
    chk("R11 reset quiet", {58'd0, long_go, mem_go, int_go, any_go, done, err}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 idle after release", {58'd0, long_go, mem_go, int_go, any_go, done, err}, 64'd0);
    for (int p = 0; p < 3; p++) begin
      for (int t = 0; t < 4; t++) begin
        for (int m = 0; m < 16; m++) begin
          run(t, m, (p == 0) ? 32'h0000_1000 :
                    (p == 1) ? 32'h8000_0A38 : 32'hFFFF_FFFC);
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule